// File: doc/BRIEF.md
# Two-Wire Bus Line Conditioner and Condition Detector

This block sits between the two open-drain pads of a two-wire serial slave and the slave's protocol engine, which runs on a much faster system clock. Each raw line is brought into the clock domain through a flop synchronizer and then cleaned by a counter-based spike filter. A line only changes its filtered level after the new value has been present for a set number of clocks, so short glitches never reach the protocol logic.

From the two filtered levels the block derives single-cycle event pulses: clock rising and falling edges, the start and stop conditions, and a data-bit strobe with the sampled data value. A bus-busy flag is held between a start and the following stop. On the transmit side, the slave asks to pull the data line low or release it, and the block passes that request to the pad only while the clock is low and only after a minimum hold time has elapsed since the filtered clock fell. This prevents the slave from creating a false start or stop itself.

Filter length, synchronizer depth and hold time are parameters given in system clocks. At 50 MHz, a 50 ns spike needs three clocks and a 300 ns hold needs fifteen.

Top module: `twl_cond_detect`

## Requirements
- R1: After reset, `scl_level` and `sda_level` are 1, `bus_busy` is 0, `sda_pull_low` is 0, and all event pulses are 0.
- R2: When a raw line changes and keeps its new value, the matching filtered level takes that value at the rising clock edge number SYNC_STAGES+FILT_CYC after the change. For the defaults, this is the fifth edge.
- R3: A raw pulse that lasts FILT_CYC-1 clocks or less leaves the filtered level unchanged and produces no event. A pulse that lasts exactly FILT_CYC clocks is passed through.
- R4: `start_pulse` is high for one cycle when filtered SDA goes from 1 to 0 while filtered SCL was 1 in both the previous cycle and the current one.
- R5: `stop_pulse` is high for one cycle when filtered SDA goes from 0 to 1 while filtered SCL was 1 in both the previous cycle and the current one.
- R6: `scl_rise` or `scl_fall` is high for exactly one cycle, in the cycle after the filtered SCL level changes. The two are never high together.
- R7: `bit_valid` is high in the same cycle as `scl_rise`, and `bit_value` then equals the new filtered SDA level. This holds even when SDA changes in that same cycle.
- R8: `bus_busy` sets in the cycle after `start_pulse` and clears in the cycle after `stop_pulse`. It changes at no other time.
- R9: `sda_pull_low` changes only while filtered SCL is low. It takes the value of `sda_drive_low` at the clock edge HOLD_CYC+1 cycles after the `scl_fall` pulse, and follows it each cycle after that until SCL rises. While SCL is high it holds its value.
- R10: An SDA edge while filtered SCL is low, or in the cycle where SCL rises, produces neither `start_pulse` nor `stop_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw clock line from the pad |
| sda_in | input | 1 | Raw data line from the pad |
| sda_drive_low | input | 1 | Slave request: 1 pulls SDA low, 0 releases it |
| sda_pull_low | output | 1 | Gated open-drain enable to the SDA pad (1 = pull low) |
| scl_level | output | 1 | Filtered clock level |
| sda_level | output | 1 | Filtered data level |
| scl_rise | output | 1 | One-cycle pulse on a filtered SCL rising edge |
| scl_fall | output | 1 | One-cycle pulse on a filtered SCL falling edge |
| start_pulse | output | 1 | One-cycle start-condition pulse |
| stop_pulse | output | 1 | One-cycle stop-condition pulse |
| bit_valid | output | 1 | Data-bit strobe, coincident with scl_rise |
| bit_value | output | 1 | Sampled data bit, valid with bit_valid |
| bus_busy | output | 1 | High between a start and a stop |

## Verification
Two functions can land in the same cycle: the data-bit strobe and an SDA edge. If both raw lines change at the same clock, both filtered levels change at the same edge. The bench provokes this by raising SCL and dropping SDA together. It then judges that a bit strobe appears carrying the new value 0, and that the start counter does not move. The boundary between a passed pulse and a rejected one is tested by driving SDA low for exactly FILT_CYC-1 clocks and then for FILT_CYC clocks while SCL is high. The first must leave the condition counters alone. The second must yield one start followed by one stop.

// File: rtl/twl_pkg.sv
package twl_pkg;

  // bits needed to hold the value n (at least one)
  function automatic int unsigned cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // start: data falls while clock stays high over both cycles
  function automatic logic is_start(logic scl_prev, logic scl_now,
                                    logic sda_prev, logic sda_now);
    return scl_prev & scl_now & sda_prev & ~sda_now;
  endfunction

  // stop: data rises while clock stays high over both cycles
  function automatic logic is_stop(logic scl_prev, logic scl_now,
                                   logic sda_prev, logic sda_now);
    return scl_prev & scl_now & ~sda_prev & sda_now;
  endfunction

endpackage

// File: rtl/twl_sync.sv
module twl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  // lines idle high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/twl_spike_filter.sv
module twl_spike_filter #(
  parameter int unsigned FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic level
);
  if (FILT_CYC < 2) begin : g_direct
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= 1'b1;
      else        level <= d;
    end
  end else begin : g_count
    localparam int unsigned CW = twl_pkg::cnt_w(FILT_CYC - 1);
    logic [CW-1:0] run;

    // level moves only after d has differed for FILT_CYC samples
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run   <= '0;
        level <= 1'b1;
      end else if (d == level) begin
        run <= '0;
      end else if (run == CW'(FILT_CYC - 1)) begin
        level <= d;
        run   <= '0;
      end else begin
        run <= run + CW'(1);
      end
    end
  end
endmodule

// File: rtl/twl_drive_gate.sv
module twl_drive_gate #(
  parameter int unsigned HOLD_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_level,
  input  logic scl_fall,
  input  logic drive_req,
  output logic pull_low
);
  localparam int unsigned HW = twl_pkg::cnt_w(HOLD_CYC);

  logic [HW-1:0] hold_cnt;
  logic          load_ok;

  // update allowed: clock low, hold window spent, no fresh fall this cycle
  assign load_ok = !scl_level && !scl_fall && (hold_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      pull_low <= 1'b0;
    end else begin
      if (scl_fall)             hold_cnt <= HW'(HOLD_CYC);
      else if (hold_cnt != '0)  hold_cnt <= hold_cnt - HW'(1);
      if (load_ok)              pull_low <= drive_req;
    end
  end
endmodule

// File: rtl/twl_cond_detect.sv
module twl_cond_detect #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_CYC    = 3,
  parameter int unsigned HOLD_CYC    = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sda_drive_low,
  output logic sda_pull_low,
  output logic scl_level,
  output logic sda_level,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_pulse,
  output logic stop_pulse,
  output logic bit_valid,
  output logic bit_value,
  output logic bus_busy
);
  import twl_pkg::*;

  localparam int unsigned IDX_SCL = 0;
  localparam int unsigned IDX_SDA = 1;
  localparam int unsigned NLINES  = 2;

  logic [NLINES-1:0] raw_w, sync_w, lvl_w;
  logic scl_sync, sda_sync;
  logic scl_q, sda_q;
  logic sda_rise_w, sda_fall_w;

  assign raw_w[IDX_SCL] = scl_in;
  assign raw_w[IDX_SDA] = sda_in;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    twl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_w[g]), .q(sync_w[g])
    );
    twl_spike_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .d(sync_w[g]), .level(lvl_w[g])
    );
  end

  assign scl_sync  = sync_w[IDX_SCL];
  assign sda_sync  = sync_w[IDX_SDA];
  assign scl_level = lvl_w[IDX_SCL];
  assign sda_level = lvl_w[IDX_SDA];

  // previous filtered levels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_level;
      sda_q <= sda_level;
    end
  end

  assign scl_rise    = scl_level & ~scl_q;
  assign scl_fall    = ~scl_level & scl_q;
  assign sda_rise_w  = sda_level & ~sda_q;
  assign sda_fall_w  = ~sda_level & sda_q;
  assign start_pulse = is_start(scl_q, scl_level, sda_q, sda_level);
  assign stop_pulse  = is_stop(scl_q, scl_level, sda_q, sda_level);
  assign bit_valid   = scl_rise;
  assign bit_value   = sda_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bus_busy <= 1'b0;
    else if (start_pulse) bus_busy <= 1'b1;
    else if (stop_pulse)  bus_busy <= 1'b0;
  end

  twl_drive_gate #(.HOLD_CYC(HOLD_CYC)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_level (scl_level),
    .scl_fall  (scl_fall),
    .drive_req (sda_drive_low),
    .pull_low  (sda_pull_low)
  );

  // data edges are exposed as named events for the checker
  logic sda_edge_any;
  assign sda_edge_any = sda_rise_w | sda_fall_w;
endmodule

// File: rtl/twl_cond_detect_chk.sv
module twl_cond_detect_chk #(
  parameter int unsigned HOLD_CYC = 15
) (
  input logic clk,
  input logic rst_n,
  input logic scl_sync,
  input logic sda_sync,
  input logic scl_level,
  input logic sda_level,
  input logic scl_rise,
  input logic scl_fall,
  input logic start_pulse,
  input logic stop_pulse,
  input logic sda_edge_any,
  input logic bus_busy,
  input logic sda_pull_low
);
  localparam int unsigned SAT = HOLD_CYC + 1;
  localparam int unsigned SW  = twl_pkg::cnt_w(SAT);

  logic [SW-1:0] since_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_fall <= SW'(SAT);
    else if (scl_fall)              since_fall <= '0;
    else if (since_fall != SW'(SAT)) since_fall <= since_fall + SW'(1);
  end

  p_scl_from_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_level) |-> ($past(scl_sync) == scl_level));

  p_sda_from_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_level) |-> ($past(sda_sync) == sda_level));

  p_start_clock_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (scl_level && $past(scl_level) && sda_edge_any));

  p_stop_clock_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> (scl_level && $past(scl_level) && sda_edge_any));

  p_edge_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall}));

  p_busy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(start_pulse));

  p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> $past(stop_pulse));

  p_drive_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_low) |-> (!$past(scl_level) && ($past(since_fall) >= SW'(HOLD_CYC))));

  p_no_cond_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> !(start_pulse || stop_pulse));
endmodule

bind twl_cond_detect twl_cond_detect_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_sync     (scl_sync),
  .sda_sync     (sda_sync),
  .scl_level    (scl_level),
  .sda_level    (sda_level),
  .scl_rise     (scl_rise),
  .scl_fall     (scl_fall),
  .start_pulse  (start_pulse),
  .stop_pulse   (stop_pulse),
  .sda_edge_any (sda_edge_any),
  .bus_busy     (bus_busy),
  .sda_pull_low (sda_pull_low)
);

// File: tb/twl_cond_detect_tb.sv
module twl_cond_detect_tb_top;
  localparam int unsigned SYN = 2;
  localparam int unsigned FLT = 3;
  localparam int unsigned HLD = 15;
  localparam int unsigned LAT = SYN + FLT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1, sda_drive_low = 1'b0;
  logic sda_pull_low, scl_level, sda_level, scl_rise, scl_fall;
  logic start_pulse, stop_pulse, bit_valid, bit_value, bus_busy;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0, n_bit = 0, n_sda_chg = 0;
  logic last_bit = 1'b1, sda_prev = 1'b1;

  always #10 clk = ~clk;

  twl_cond_detect #(.SYNC_STAGES(SYN), .FILT_CYC(FLT), .HOLD_CYC(HLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_drive_low(sda_drive_low), .sda_pull_low(sda_pull_low),
    .scl_level(scl_level), .sda_level(sda_level), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .bit_valid(bit_valid), .bit_value(bit_value), .bus_busy(bus_busy)
  );

  // event monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (start_pulse) n_start++;
      if (stop_pulse)  n_stop++;
      if (scl_rise)    n_rise++;
      if (scl_fall)    n_fall++;
      if (bit_valid) begin n_bit++; last_bit = bit_value; end
      if (sda_level != sda_prev) n_sda_chg++;
      sda_prev = sda_level;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic d);
    scl_in = c; sda_in = d;
  endtask

  task automatic t_reset();
    chk("R1 scl_level", scl_level, 1);
    chk("R1 sda_level", sda_level, 1);
    chk("R1 bus_busy", bus_busy, 0);
    chk("R1 sda_pull_low", sda_pull_low, 0);
    chk("R1 pulses", {start_pulse, stop_pulse, scl_rise, scl_fall, bit_valid}, 0);
  endtask

  task automatic t_latency();
    int f0 = n_fall, r0 = n_rise;
    drive(1'b0, 1'b1);
    wait_n(LAT - 1);
    chk("R2 level before latency", scl_level, 1);
    wait_n(1);
    chk("R2 level at latency", scl_level, 0);
    chk("R6 fall pulse", scl_fall, 1);
    wait_n(1);
    chk("R6 fall pulse single", scl_fall, 0);
    drive(1'b1, 1'b1);
    wait_n(LAT + 3);
    chk("R6 fall count", n_fall - f0, 1);
    chk("R6 rise count", n_rise - r0, 1);
  endtask

  task automatic t_glitch();
    int s0 = n_start, p0 = n_stop, c0 = n_sda_chg;
    drive(1'b1, 1'b0);
    wait_n(FLT - 1);
    drive(1'b1, 1'b1);
    wait_n(LAT + 4);
    chk("R3 short pulse level", n_sda_chg - c0, 0);
    chk("R3 short pulse start", n_start - s0, 0);
    chk("R3 short pulse stop", n_stop - p0, 0);
    drive(1'b1, 1'b0);
    wait_n(FLT);
    drive(1'b1, 1'b1);
    wait_n(LAT + 4);
    chk("R3 boundary pulse start", n_start - s0, 1);
    chk("R3 boundary pulse stop", n_stop - p0, 1);
    chk("R8 busy after start+stop", bus_busy, 0);
  endtask

  task automatic clk_bit(input logic b);
    drive(1'b0, sda_in); wait_n(LAT + 2);
    drive(1'b0, b);      wait_n(LAT + 2);
    drive(1'b1, b);      wait_n(LAT + 2);
  endtask

  task automatic t_transfer();
    int s0 = n_start, p0 = n_stop, b0 = n_bit;
    drive(1'b1, 1'b0);
    wait_n(LAT);
    chk("R4 start pulse", start_pulse, 1);
    wait_n(1);
    chk("R4 start single", start_pulse, 0);
    chk("R8 busy set", bus_busy, 1);
    clk_bit(1'b1);
    chk("R7 bit one", last_bit, 1);
    clk_bit(1'b0);
    chk("R7 bit zero", last_bit, 0);
    chk("R10 no cond on low-phase edges", (n_start - s0) * 10 + (n_stop - p0), 10);
    // clock low with data high, then clock up and data down together
    drive(1'b0, 1'b0); wait_n(LAT + 2);
    drive(1'b0, 1'b1); wait_n(LAT + 2);
    drive(1'b1, 1'b0);
    wait_n(LAT);
    chk("R7 coincident strobe", bit_valid, 1);
    chk("R7 coincident value", bit_value, 0);
    chk("R10 no start on coincident edge", start_pulse, 0);
    wait_n(3);
    chk("R10 start count", n_start - s0, 1);
    chk("R7 bit count", n_bit - b0, 3);
    drive(1'b1, 1'b1);
    wait_n(LAT);
    chk("R5 stop pulse", stop_pulse, 1);
    wait_n(1);
    chk("R8 busy cleared", bus_busy, 0);
    chk("R5 stop count", n_stop - p0, 1);
  endtask

  task automatic t_gate();
    sda_drive_low = 1'b1;
    wait_n(20);
    chk("R9 held while scl high", sda_pull_low, 0);
    drive(1'b0, 1'b1);
    wait_n(LAT + 1 + HLD);
    chk("R9 not before hold", sda_pull_low, 0);
    wait_n(1);
    chk("R9 loads after hold", sda_pull_low, 1);
    sda_drive_low = 1'b0;
    wait_n(1);
    chk("R9 follows while low", sda_pull_low, 0);
    drive(1'b1, 1'b1);
    wait_n(LAT + 1);
    sda_drive_low = 1'b1;
    wait_n(20);
    chk("R9 frozen in high phase", sda_pull_low, 0);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(2);
    t_latency();
    t_glitch();
    t_transfer();
    t_gate();
    finish_run();
  end
endmodule